// File: doc/BRIEF.md
# Bridge I/O Window Decoder

This block keeps the I/O window configuration of a PCI-to-PCI bridge. It also decides, for each I/O address it sees, whether that address belongs to the window forwarded to the secondary bus. Software sets the window through a 16-bit register. The register holds two writable 4-bit fields:

- a limit nibble in bits 15:12;
- a base nibble in bits 7:4.

The remaining bits are read-only capability fields. They read as zero, which reports that only 16-bit I/O decode is supported.

The window has 4 KB granularity. The window starts at the base nibble followed by 000h. It ends at the limit nibble followed by FFFh. An incoming I/O address is compared against this range, and a single claim signal comes out combinationally in the same cycle.

An address that has any bit above bit 15 set is never claimed. If the limit nibble is below the base nibble, the window is empty.

Top module: `io_window_decoder`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the register is cleared, so that `cfg_rdata` reads 0000h in the following cycle. In the reset state, base and limit are both 0h, so addresses 0000h to 0FFFh are claimed and 1000h is not.
- R2: When `cfg_wr` is high at a rising edge, bits 15:12 of `cfg_wdata` become the limit nibble and bits 7:4 become the base nibble. From the next cycle these values read back at the same positions of `cfg_rdata`.
- R3: Bits 11:8 and 3:0 of `cfg_rdata` always read 0h, and writing ones to those bits of `cfg_wdata` has no effect on anything.
- R4: `io_claim` is high exactly when the address is at or above {base, 000h} and at or below {limit, FFFh}, with all address bits above 15 zero. This includes both edge addresses.
- R5: When the limit nibble is less than the base nibble, `io_claim` stays low for every address.
- R6: An address with any bit above bit 15 set is never claimed, even when its low 16 bits fall inside the window.
- R7: `io_claim` follows `io_addr` in the same cycle with no register in between. A write changes the claim result from the cycle after the write edge.
- R8: When `cfg_wr` is low, the register holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_wdata | input | 16 | Register write data |
| cfg_rdata | output | 16 | Register read value |
| io_addr | input | ADDR_W | I/O address under test |
| io_claim | output | 1 | Address lies inside the forwarded window |

## Verification
The bench builds the decoder with `ADDR_W` set to 24. This places eight address bits above bit 15 within reach, so the rejection of high addresses can be driven both with a single high bit and with all high bits set, on top of low bits that match the window. The default nibble width and granularity are kept. This makes every base and limit nibble pair, including the single-block window and both extreme windows, reachable by directed writes.

// File: rtl/io_win_pkg.sv
// io_win_pkg: shared constants and the window configuration type for the
// bridge I/O window decoder. Assumes a 16-bit I/O space and 4 KB blocks.
package io_win_pkg;
    localparam int WIN_AW   = 16;               // decoded I/O address width
    localparam int GRAN_LG  = 12;               // log2 of window granularity
    localparam int NIB_W    = WIN_AW - GRAN_LG; // width of base/limit fields
    localparam int REG_W    = 16;               // register width
    localparam int LIM_MSB  = REG_W - 1;        // limit field top bit
    localparam int BASE_MSB = REG_W / 2 - 1;    // base field top bit

    typedef struct packed {
        logic [NIB_W-1:0] lim_nib;
        logic [NIB_W-1:0] base_nib;
    } win_cfg_t;
endpackage

// File: rtl/io_win_cfg_reg.sv
// io_win_cfg_reg: holds the writable base and limit nibbles and builds the
// read value with the capability fields tied to zero.
// Assumes a full 16-bit write on every strobe (no byte enables).
module io_win_cfg_reg
    import io_win_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wdata,
    output win_cfg_t         cfg,
    output logic [REG_W-1:0] rdata
);
    win_cfg_t cfg_q;

    // Capture the two nibbles on a write; clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else if (wr_en) begin
            cfg_q.lim_nib  <= wdata[LIM_MSB -: NIB_W];
            cfg_q.base_nib <= wdata[BASE_MSB -: NIB_W];
        end
    end

    // Place the nibbles in the read value; every other bit reads zero.
    always_comb begin
        rdata                    = '0;
        rdata[LIM_MSB -: NIB_W]  = cfg_q.lim_nib;
        rdata[BASE_MSB -: NIB_W] = cfg_q.base_nib;
    end

    assign cfg = cfg_q;
endmodule

// File: rtl/io_win_match.sv
// io_win_match: combinational range compare of an I/O address against the
// padded window. Because the padding is 000h below and FFFh above, only the
// upper nibble of the address needs comparing. Bits above the 16-bit space
// force a miss.
module io_win_match
    import io_win_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  win_cfg_t          cfg,
    input  logic [ADDR_W-1:0] addr,
    output logic              hit
);
    logic [NIB_W-1:0] addr_nib;
    logic             above_space;
    logic             in_range;

    assign addr_nib = addr[WIN_AW-1 -: NIB_W];

    // Choose whether high address bits exist to be checked.
    generate
        if (ADDR_W > WIN_AW) begin : g_high
            assign above_space = |addr[ADDR_W-1:WIN_AW];
        end else begin : g_nohigh
            assign above_space = 1'b0;
        end
    endgenerate

    // Block-level compare; an empty window (limit < base) never satisfies both.
    always_comb begin
        in_range = (addr_nib >= cfg.base_nib) && (addr_nib <= cfg.lim_nib);
        hit      = in_range && !above_space;
    end
endmodule

// File: rtl/io_window_decoder.sv
// io_window_decoder: top of the bridge I/O window decoder. Connects the
// configuration register to the address comparator.
// Assumes ADDR_W >= 16 and a synchronous active-low reset.
module io_window_decoder
    import io_win_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic [15:0]       cfg_wdata,
    output logic [15:0]       cfg_rdata,
    input  logic [ADDR_W-1:0] io_addr,
    output logic              io_claim
);
    win_cfg_t win_cfg;

    io_win_cfg_reg u_cfg (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (cfg_wr),
        .wdata (cfg_wdata),
        .cfg   (win_cfg),
        .rdata (cfg_rdata)
    );

    io_win_match #(.ADDR_W(ADDR_W)) u_match (
        .cfg  (win_cfg),
        .addr (io_addr),
        .hit  (io_claim)
    );
endmodule

// File: rtl/io_window_checker.sv
// io_window_checker: port-level properties of io_window_decoder, attached
// to it with bind.
module io_window_checker #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_wr,
    input logic [15:0]       cfg_wdata,
    input logic [15:0]       cfg_rdata,
    input logic [ADDR_W-1:0] io_addr,
    input logic              io_claim
);
    // R1: a reset edge leaves the register reading zero.
    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> cfg_rdata == 16'h0000);

    // R2: written nibbles appear in the read value in the next cycle.
    p_write_take_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr |=> (cfg_rdata[15:12] == $past(cfg_wdata[15:12]))
                && (cfg_rdata[7:4] == $past(cfg_wdata[7:4])));

    // R3: the capability fields always read zero.
    p_cap_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_rdata[11:8] == 4'h0) && (cfg_rdata[3:0] == 4'h0));

    // R4: a claimed address lies between the padded base and limit.
    p_claim_inside_r4: assert property (@(posedge clk) disable iff (!rst_n)
        io_claim |-> (io_addr[15:12] >= cfg_rdata[7:4])
                  && (io_addr[15:12] <= cfg_rdata[15:12]));

    // R5: an inverted window claims nothing.
    p_empty_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_rdata[15:12] < cfg_rdata[7:4]) |-> !io_claim);

    // R8: without a write the register is unchanged.
    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_wr |=> $stable(cfg_rdata));

    generate
        if (ADDR_W > 16) begin : g_high
            // R6: addresses above the 16-bit space are never claimed.
            p_high_miss_r6: assert property (@(posedge clk) disable iff (!rst_n)
                (|io_addr[ADDR_W-1:16]) |-> !io_claim);
        end
    endgenerate
endmodule

bind io_window_decoder io_window_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_wr    (cfg_wr),
    .cfg_wdata (cfg_wdata),
    .cfg_rdata (cfg_rdata),
    .io_addr   (io_addr),
    .io_claim  (io_claim)
);

// File: tb/test_io_window_decoder.sv
// Directed bench for io_window_decoder: one task per scenario.
// Inputs change on the falling edge and outputs are sampled 1 ns later.
module test_io_window_decoder;
    localparam int AW = 24;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_wr = 1'b0;
    logic [15:0]   cfg_wdata = '0;
    logic [15:0]   cfg_rdata;
    logic [AW-1:0] io_addr = '0;
    logic          io_claim;
    int            checks = 0;
    int            errors = 0;
    logic [3:0]    cur_base = 4'h0;
    logic [3:0]    cur_lim  = 4'h0;

    always #2 clk = ~clk;   // 250 MHz

    io_window_decoder #(.ADDR_W(AW)) i_io_window_decoder (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_wr    (cfg_wr),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .io_addr   (io_addr),
        .io_claim  (io_claim)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic model_claim(input logic [AW-1:0] a);
        logic [15:0] lo;
        lo = a[15:0];
        return (a[AW-1:16] == '0) && (lo >= {cur_base, 12'h000})
            && (lo <= {cur_lim, 12'hFFF});
    endfunction

    task automatic write_reg(input logic [15:0] d);
        @(negedge clk);
        cfg_wr = 1'b1;
        cfg_wdata = d;
        @(negedge clk);
        cfg_wr = 1'b0;
        cfg_wdata = 16'h0000;
        cur_lim  = d[15:12];
        cur_base = d[7:4];
        #1;
    endtask

    task automatic probe(input string req, input logic [AW-1:0] a);
        io_addr = a;
        #1;
        check(req, {31'b0, io_claim}, {31'b0, model_claim(a)});
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        #1;
        cur_base = 4'h0; cur_lim = 4'h0;
        check("R1 rdata", {16'b0, cfg_rdata}, 32'h0);
        probe("R1 claim 0FFF", 24'h000FFF);
        probe("R1 claim 1000", 24'h001000);
        check("R1 explicit", {31'b0, io_claim}, 32'h0);
    endtask

    task automatic t_write_readback();
        write_reg(16'hA050);
        check("R2 readback", {16'b0, cfg_rdata}, 32'h0000A050);
        write_reg(16'h3010);
        check("R2 readback2", {16'b0, cfg_rdata}, 32'h00003010);
    endtask

    task automatic t_cap_ignore();
        write_reg(16'hFFFF);
        check("R3 cap bits", {16'b0, cfg_rdata}, 32'h0000F0F0);
        write_reg(16'h0F0F);
        check("R3 cap only", {16'b0, cfg_rdata}, 32'h0);
        probe("R3 claim", 24'h000800);
    endtask

    task automatic t_edges();
        write_reg(16'h7030);
        probe("R4 below base", 24'h002FFF);
        probe("R4 at base", 24'h003000);
        check("R4 at base hi", {31'b0, io_claim}, 32'h1);
        probe("R4 middle", 24'h005A5A);
        probe("R4 at limit", 24'h007FFF);
        check("R4 at limit hi", {31'b0, io_claim}, 32'h1);
        probe("R4 above limit", 24'h008000);
        write_reg(16'h9090);
        probe("R4 single lo", 24'h009000);
        probe("R4 single hi", 24'h009FFF);
        probe("R4 single out", 24'h00A000);
        write_reg(16'hF000);
        probe("R4 full lo", 24'h000000);
        probe("R4 full hi", 24'h00FFFF);
    endtask

    task automatic t_empty();
        write_reg(16'h4050);
        for (int n = 0; n < 16; n++) begin
            probe("R5 empty", {8'h00, n[3:0], 12'h800});
        end
        check("R5 explicit", {31'b0, io_claim}, 32'h0);
    endtask

    task automatic t_high_bits();
        write_reg(16'hF000);
        probe("R6 bit16", 24'h010000);
        probe("R6 all high", 24'hFF1234);
        check("R6 explicit", {31'b0, io_claim}, 32'h0);
        probe("R6 low ok", 24'h001234);
    endtask

    task automatic t_timing();
        write_reg(16'h2020);
        io_addr = 24'h005000;
        @(negedge clk);
        cfg_wr = 1'b1; cfg_wdata = 16'h5050;
        #1;
        check("R7 before edge", {31'b0, io_claim}, 32'h0);
        @(negedge clk);
        cfg_wr = 1'b0;
        #1;
        check("R7 after edge", {31'b0, io_claim}, 32'h1);
        cur_base = 4'h5; cur_lim = 4'h5;
        io_addr = 24'h002000;
        #1;
        check("R7 same cycle", {31'b0, io_claim}, 32'h0);
    endtask

    task automatic t_hold();
        write_reg(16'hC060);
        cfg_wdata = 16'h1010;
        repeat (4) @(negedge clk);
        #1;
        check("R8 hold", {16'b0, cfg_rdata}, 32'h0000C060);
        probe("R8 claim", 24'h00B000);
    endtask

    initial begin
        fork
            begin
                t_reset();
                t_write_readback();
                t_cap_ignore();
                t_edges();
                t_empty();
                t_high_bits();
                t_timing();
                t_hold();
                t_reset();
            end
            begin
                repeat (20000) @(posedge clk);
                errors++;
                checks++;
                $display("FAIL watchdog actual=expired expected=done");
            end
        join_any
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule